// File: doc/BRIEF.md
# Autonegotiation Speed Downshift Controller

This controller decides which line speeds an Ethernet transceiver offers while autonegotiating. A start pulse sets it to offer gigabit, fast and 10 Mb/s operation together. It then counts failed link bring-up attempts. Once a programmable number of failures in a row is reached, it drops the fastest speed still offered and asks the negotiation logic to restart. Each further run of failures takes away one more speed.

When only 10 Mb/s is left and that tier also fails, the controller offers everything again and the sequence begins anew. A control bit can rule out the 10 Mb/s-only tier, in which case failures at the 100 Mb/s tier go straight back to all speeds. A second bit turns the whole mechanism off.

All pins are plain level or pulse controls: there is no data stream and no handshake. The advertised-abilities vector changes only as the tier changes. The restart output is a one-cycle strobe meant to trigger the negotiation engine.

Top module: `speed_downshift_ctrl`

## Requirements
- R1: After reset, `tier_o` is 0, `adv_o` is 3'b111 and `restart_o` is low.
- R2: A `start_i` pulse sampled on a clock edge sets the tier to 0 and clears the failure count at that edge. It also raises `restart_o` for the following cycle. `start_i` has priority over every other input.
- R3: The failure threshold is `thresh_sel_i`+1, so field values 0..3 give 1..4 attempts. The tier changes at the edge that samples the threshold-th consecutive `fail_i` pulse.
- R4: Tiers step in the order 0, 1, 2. `adv_o` bit 2 is 1000 Mb/s, bit 1 is 100 Mb/s and bit 0 is 10 Mb/s. Tier 0 gives 3'b111, tier 1 gives 3'b011 and tier 2 gives 3'b001.
- R5: Reaching the threshold at tier 2 returns the controller to tier 0 (3'b111) and issues a restart.
- R6: With `allow_10_i` low, reaching the threshold at tier 1 returns the controller to tier 0 instead of going to tier 2.
- R7: With `dshift_en_i` low, `adv_o` is 3'b111 in that same cycle and the tier becomes 0 at the next edge. Failures are ignored and no restart is issued, except one caused by `start_i`.
- R8: While `link_up_i` is high, `fail_i` is ignored, the tier is held and the failure count is cleared. Counting starts from zero after the link drops.
- R9: `restart_o` is high for exactly one cycle after each tier change, including the wrap to tier 0. It stays low when failures remain below the threshold.
- R10: `tier_o` reports the tier as 0 for all speeds, 1 for 100 Mb/s maximum and 2 for 10 Mb/s only, and never shows 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a fresh negotiation sequence at all speeds |
| fail_i | input | 1 | One-cycle pulse per failed link attempt |
| link_up_i | input | 1 | Link is established |
| dshift_en_i | input | 1 | Enable stepwise speed reduction |
| allow_10_i | input | 1 | Permit the 10 Mb/s-only tier |
| thresh_sel_i | input | 2 | Failed attempts before a step, minus one |
| adv_o | output | 3 | Advertised speeds {1000,100,10} |
| restart_o | output | 1 | One-cycle autonegotiation restart strobe |
| tier_o | output | 2 | Current tier |

## Verification
On every cycle the assertions check the following: the tier range; that start forces tier 0 with a restart; that the tier holds while the link is up; that the tier returns to 0 silently when disabled; that every tier change comes with a restart strobe; and that tier 2 is entered only from tier 1 with 10 Mb/s allowed. Only the bench scenarios can show the exact failure counts at which steps occur for each threshold setting, the wrap after the lowest tier, and the number of restarts over a run. They also show that a link-up period discards failures already counted.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int unsigned SD_NUM_SPEEDS = 3;
  localparam int unsigned SD_SEL_W      = 2;
  localparam int unsigned SD_TIER_W     = $clog2(SD_NUM_SPEEDS);

  typedef logic [SD_TIER_W-1:0] sd_tier_t;

  localparam sd_tier_t SD_TIER_ALL = '0;
endpackage

// File: rtl/sd_fail_counter.sv
module sd_fail_counter #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [SEL_W-1:0] cnt_q;

  // The count holds prior failures, so an equal compare means this
  // failure is number sel+1.
  assign hit = inc && (cnt_q == sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || hit) cnt_q <= '0;
    else if (inc)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sd_tier_seq.sv
module sd_tier_seq
  import sd_pkg::*;
#(
  parameter int unsigned NUM_SPEEDS = SD_NUM_SPEEDS,
  parameter int unsigned TIER_W     = $clog2(NUM_SPEEDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              enable,
  input  logic              step,
  input  logic              allow_low,
  output logic [TIER_W-1:0] tier,
  output logic              restart
);
  localparam logic [TIER_W-1:0] LAST     = TIER_W'(NUM_SPEEDS - 1);
  localparam logic [TIER_W-1:0] PRE_LAST = TIER_W'(NUM_SPEEDS - 2);

  logic [TIER_W-1:0] tier_q, nxt_tier;
  logic              rst_q;

  always_comb begin
    if (tier_q == LAST || (tier_q == PRE_LAST && !allow_low))
      nxt_tier = '0;
    else
      nxt_tier = tier_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tier_q <= '0;
      rst_q  <= 1'b0;
    end else if (start) begin
      tier_q <= '0;
      rst_q  <= 1'b1;
    end else if (!enable) begin
      tier_q <= '0;
      rst_q  <= 1'b0;
    end else if (step) begin
      tier_q <= nxt_tier;
      rst_q  <= 1'b1;
    end else begin
      rst_q  <= 1'b0;
    end
  end

  assign tier    = tier_q;
  assign restart = rst_q;
endmodule

// File: rtl/sd_adv_map.sv
module sd_adv_map #(
  parameter int unsigned NUM_SPEEDS = 3,
  parameter int unsigned TIER_W     = $clog2(NUM_SPEEDS)
) (
  input  logic [TIER_W-1:0]     tier,
  input  logic                  force_all,
  output logic [NUM_SPEEDS-1:0] adv
);
  // Bit NUM_SPEEDS-1 is the fastest speed; tier t removes the t fastest.
  for (genvar i = 0; i < NUM_SPEEDS; i++) begin : g_bit
    assign adv[i] = force_all || (int'(tier) <= (NUM_SPEEDS - 1 - i));
  end
endmodule

// File: rtl/speed_downshift_ctrl.sv
module speed_downshift_ctrl
  import sd_pkg::*;
#(
  parameter int unsigned NUM_SPEEDS = SD_NUM_SPEEDS,
  parameter int unsigned SEL_W      = SD_SEL_W,
  parameter int unsigned TIER_W     = $clog2(NUM_SPEEDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  fail_i,
  input  logic                  link_up_i,
  input  logic                  dshift_en_i,
  input  logic                  allow_10_i,
  input  logic [SEL_W-1:0]      thresh_sel_i,
  output logic [NUM_SPEEDS-1:0] adv_o,
  output logic                  restart_o,
  output logic [TIER_W-1:0]     tier_o
);
  logic fail_ok, cnt_clr, step;

  assign fail_ok = fail_i && dshift_en_i && !link_up_i && !start_i;
  assign cnt_clr = start_i || !dshift_en_i || link_up_i;

  sd_fail_counter #(.SEL_W(SEL_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (fail_ok),
    .sel   (thresh_sel_i),
    .hit   (step)
  );

  sd_tier_seq #(.NUM_SPEEDS(NUM_SPEEDS), .TIER_W(TIER_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .enable    (dshift_en_i),
    .step      (step),
    .allow_low (allow_10_i),
    .tier      (tier_o),
    .restart   (restart_o)
  );

  sd_adv_map #(.NUM_SPEEDS(NUM_SPEEDS), .TIER_W(TIER_W)) u_map (
    .tier      (tier_o),
    .force_all (!dshift_en_i),
    .adv       (adv_o)
  );
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
  parameter int unsigned NUM_SPEEDS = 3,
  parameter int unsigned TIER_W     = $clog2(NUM_SPEEDS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  link_up_i,
  input logic                  dshift_en_i,
  input logic                  allow_10_i,
  input logic [NUM_SPEEDS-1:0] adv_o,
  input logic                  restart_o,
  input logic [TIER_W-1:0]     tier_o
);
  localparam logic [TIER_W-1:0] LAST = TIER_W'(NUM_SPEEDS - 1);

  assert_tier_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tier_o <= LAST);

  assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (tier_o == '0) && restart_o);

  assert_link_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up_i && dshift_en_i && !start_i) |=> $stable(tier_o));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dshift_en_i && !start_i) |=> (tier_o == '0) && !restart_o);

  assert_change_pulses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tier_o != $past(tier_o)) && $past(dshift_en_i) |-> restart_o);

  assert_low_tier_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tier_o == LAST) && ($past(tier_o) != LAST) |-> $past(allow_10_i));
endmodule

bind speed_downshift_ctrl sd_checker #(.NUM_SPEEDS(NUM_SPEEDS), .TIER_W(TIER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .link_up_i   (link_up_i),
  .dshift_en_i (dshift_en_i),
  .allow_10_i  (allow_10_i),
  .adv_o       (adv_o),
  .restart_o   (restart_o),
  .tier_o      (tier_o)
);

// File: tb/sim_speed_downshift_ctrl.sv
`timescale 1ns/1ps
module sim_speed_downshift_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, fail_i = 1'b0, link_up_i = 1'b0;
  logic       dshift_en_i = 1'b1, allow_10_i = 1'b1;
  logic [1:0] thresh_sel_i = 2'd0;
  logic [2:0] adv_o;
  logic       restart_o;
  logic [1:0] tier_o;

  int checks = 0, errors = 0, rcount = 0;

  always #2.5 clk = ~clk;

  speed_downshift_ctrl u0 (.*);

  // {en, allow10, sel[1:0], fails[3:0], tier[1:0], adv[2:0], restarts[2:0]}
  localparam logic [15:0] VEC [10] = '{
    {1'b1,1'b1,2'd0,4'd1,2'd1,3'b011,3'd1},   // R3 R4
    {1'b1,1'b1,2'd0,4'd2,2'd2,3'b001,3'd2},   // R4
    {1'b1,1'b1,2'd0,4'd3,2'd0,3'b111,3'd3},   // R5
    {1'b1,1'b1,2'd3,4'd3,2'd0,3'b111,3'd0},   // R3 below threshold
    {1'b1,1'b1,2'd3,4'd4,2'd1,3'b011,3'd1},   // R3
    {1'b1,1'b0,2'd1,4'd4,2'd0,3'b111,3'd2},   // R6
    {1'b1,1'b0,2'd1,4'd3,2'd1,3'b011,3'd1},   // R6
    {1'b0,1'b1,2'd0,4'd5,2'd0,3'b111,3'd0},   // R7
    {1'b1,1'b1,2'd2,4'd6,2'd2,3'b001,3'd2},   // R3 R4
    {1'b1,1'b1,2'd1,4'd5,2'd2,3'b001,3'd2}    // R3
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R2 restart after start", restart_o, 1);
    chk("R2 tier after start", tier_o, 0);
    @(negedge clk);
    chk("R9 restart one cycle", restart_o, 0);
    rcount = 0;
  endtask

  task automatic do_fail();
    @(negedge clk) fail_i = 1'b1;
    @(negedge clk) fail_i = 1'b0;
    if (restart_o) rcount++;
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tier", tier_o, 0);
    chk("R1 adv", adv_o, 3'b111);
    chk("R1 restart", restart_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tier after release", tier_o, 0);

    for (int v = 0; v < 10; v++) begin
      dshift_en_i  = VEC[v][15];
      allow_10_i   = VEC[v][14];
      thresh_sel_i = VEC[v][13:12];
      do_start();
      for (int f = 0; f < int'(VEC[v][11:8]); f++) do_fail();
      @(negedge clk);
      chk($sformatf("R4 R10 tier vec%0d", v), tier_o, VEC[v][7:6]);
      chk($sformatf("R4 adv vec%0d", v), adv_o, VEC[v][5:3]);
      chk($sformatf("R9 restarts vec%0d", v), rcount, VEC[v][2:0]);
      chk($sformatf("R9 no lingering restart vec%0d", v), restart_o, 0);
    end

    // R8: failures during link-up are ignored and the count is cleared
    dshift_en_i = 1'b1; allow_10_i = 1'b1; thresh_sel_i = 2'd1;
    do_start();
    do_fail();
    @(negedge clk) link_up_i = 1'b1;
    for (int f = 0; f < 3; f++) do_fail();
    chk("R8 tier held during link", tier_o, 0);
    chk("R8 no restart during link", rcount, 0);
    @(negedge clk) link_up_i = 1'b0;
    do_fail();
    chk("R8 count cleared by link", tier_o, 0);
    do_fail();
    chk("R8 step after fresh count", tier_o, 1);
    chk("R9 restart on step", rcount, 1);
    @(negedge clk) link_up_i = 1'b1;
    for (int f = 0; f < 4; f++) do_fail();
    chk("R8 tier 1 held during link", tier_o, 1);
    chk("R8 adv held", adv_o, 3'b011);
    link_up_i = 1'b0;

    // R7: disabling at tier 1 returns to all speeds without a restart
    thresh_sel_i = 2'd0;
    do_start();
    do_fail();
    chk("R7 setup tier", tier_o, 1);
    @(negedge clk) dshift_en_i = 1'b0;
    #1;
    chk("R7 adv forced same cycle", adv_o, 3'b111);
    @(negedge clk);
    chk("R7 tier zero", tier_o, 0);
    chk("R7 no restart", restart_o, 0);
    dshift_en_i = 1'b1;

    // R2: start from the lowest tier
    do_start();
    do_fail(); do_fail();
    chk("R2 setup tier 2", tier_o, 2);
    do_start();
    chk("R2 adv after start", adv_o, 3'b111);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule